// File: doc/BRIEF.md
# Nibble Data Pointer and Memory Exchange Unit

This block holds the data pointers, accumulator and zero flag of a 4-bit controller core. It carries out the instructions that move a nibble between the accumulator and data RAM. Two pointer pairs, HL and XY, each join a high and a low nibble into an 8-bit RAM address. One opcode bit chooses the pair. After the access, the step forms add one to or subtract one from only the low nibble of that pair. The zero flag then shows whether the stepped nibble became zero. It does not reflect the nibble that was moved.

The core presents one instruction at a time on `instr_op`, and the second byte, if there is one, on `instr_imm`. The unit takes the instruction when `instr_valid` and `instr_ready` are both high. Pointer loads with immediates finish at the accepting edge. Memory instructions read the synchronous RAM at the accepting edge and finish one edge later. An exchange writes the old accumulator back to the same address in that second cycle. A one-cycle `done` pulse marks each finished instruction, and `done_cycles` gives the nominal machine-cycle cost of that instruction.

Top module: `nptr_unit`

## Requirements
- R1: A memory access uses the address {high, low} of the pair chosen by opcode bit 1 (0 = HL, 1 = XY), or the second byte for the direct exchange. An exchange writes to the address it read in the cycle before.
- R2: Load with post-increment (0100_10p1, p = pair bit) puts M(pair) in the accumulator and adds 1 to the low nibble of that pair. The high nibble does not change.
- R3: Load with post-decrement (0101_10p1) puts M(pair) in the accumulator and subtracts 1 from the low nibble of that pair.
- R4: Plain exchange (0100_11p0) swaps the accumulator with M(pair). It leaves both pointers and the zero flag unchanged.
- R5: Exchange with post-increment (0100_11p1) and exchange with post-decrement (0101_11p1) swap the accumulator with M(pair), then step the low nibble of that pair.
- R6: A low nibble steps modulo 16. After every step, the zero flag equals (new low nibble == 0): 0xF+1 gives 0 with the flag set, and 0x0-1 gives 0xF with the flag clear.
- R7: LDZ (0110_iiii) clears the HL high nibble and loads iiii into the HL low nibble. The zero flag does not change.
- R8: Pair load 0xC4 (HL) or 0xC5 (XY) writes second-byte bits 7..4 to the high nibble and bits 3..0 to the low nibble. The zero flag does not change.
- R9: Direct exchange (0xC2) swaps the accumulator with M(second byte). Pointers and the zero flag are unchanged.
- R10: Immediate loads assert `done` one edge after acceptance. Memory instructions hold `instr_ready` low for one cycle and assert `done` two edges after acceptance. `done_cycles` reads 1 for LDZ and the plain exchange, and 2 for the rest.
- R11: Every other opcode is accepted and ignored: no state change, no RAM access, no `done`.
- R12: Reset clears both pointers, the accumulator and the zero flag, drops `done`, and raises `instr_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction present |
| instr_op | input | 8 | Opcode byte |
| instr_imm | input | 8 | Second byte (immediate or direct address) |
| instr_ready | output | 1 | Unit idle, instruction accepted this cycle |
| done | output | 1 | One-cycle pulse when an instruction finishes |
| done_cycles | output | 2 | Nominal cycle cost of the finishing instruction |
| ram_re | output | 1 | RAM read strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 4 | RAM write data |
| ram_rdata | input | 4 | RAM read data, valid the cycle after a read |
| acc | output | 4 | Accumulator |
| zflag | output | 1 | Zero flag |
| hl_ptr | output | 8 | HL pair {high, low} |
| xy_ptr | output | 8 | XY pair {high, low} |

## Verification
An immediate load changes its pointer at the edge that accepts it. A memory instruction issues its read address in the accepting cycle, then updates the accumulator, the step and the write-back at the following edge. The bench drives each instruction on a falling edge and checks the RAM address in that same half-cycle. It then counts falling edges until `done` appears, expecting one for immediate loads and two for memory instructions. It compares registers and RAM contents on the falling edge where `done` is high. For an ignored opcode it waits four edges to confirm that `done` never appears.

// File: rtl/nptr_pkg.sv
package nptr_pkg;

  localparam int OP_W = 8;

  localparam logic [OP_W-1:0] OP_XDIR = 8'hC2;
  localparam logic [OP_W-1:0] OP_LDHL = 8'hC4;
  localparam logic [OP_W-1:0] OP_LDXY = 8'hC5;

  typedef enum logic [2:0] {
    K_NONE,
    K_LDZ,
    K_LDPAIR,
    K_LOAD,
    K_XCH,
    K_XDIR
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic       pair;   // 0 = HL, 1 = XY
    logic       step;   // low nibble steps after access
    logic       down;   // step direction
    logic [1:0] cyc;    // nominal machine cycles
  } dec_t;

  function automatic dec_t nptr_decode_op(input logic [OP_W-1:0] op);
    dec_t d;
    d.kind = K_NONE;
    d.pair = op[1];
    d.step = 1'b0;
    d.down = op[4];
    d.cyc  = 2'd0;
    if (op[7:4] == 4'b0110) begin
      d.kind = K_LDZ;
      d.pair = 1'b0;
      d.cyc  = 2'd1;
    end else if (op[7:5] == 3'b010 && op[3]) begin
      if (!op[2]) begin
        if (op[0]) begin
          d.kind = K_LOAD;
          d.step = 1'b1;
          d.cyc  = 2'd2;
        end
      end else if (op[0]) begin
        d.kind = K_XCH;
        d.step = 1'b1;
        d.cyc  = 2'd2;
      end else if (!op[4]) begin
        d.kind = K_XCH;
        d.cyc  = 2'd1;
      end
    end else if (op == OP_XDIR) begin
      d.kind = K_XDIR;
      d.cyc  = 2'd2;
    end else if (op == OP_LDHL || op == OP_LDXY) begin
      d.kind = K_LDPAIR;
      d.pair = op[0];
      d.cyc  = 2'd2;
    end
    return d;
  endfunction

  function automatic logic is_mem_kind(input kind_e k);
    return (k == K_LOAD) || (k == K_XCH) || (k == K_XDIR);
  endfunction

endpackage

// File: rtl/nptr_decode.sv
module nptr_decode
  import nptr_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output dec_t            dec,
  output logic            is_mem
);

  always_comb begin
    dec    = nptr_decode_op(op);
    is_mem = is_mem_kind(dec.kind);
  end

endmodule

// File: rtl/nptr_ptrfile.sv
module nptr_ptrfile #(
  parameter int PTR_W  = 4,
  parameter int DATA_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                imm_we,
  input  logic                imm_pair,
  input  logic [PTR_W-1:0]    imm_hi,
  input  logic [PTR_W-1:0]    imm_lo,
  input  logic                ac_we,
  input  logic [DATA_W-1:0]   ac_d,
  input  logic                step_fire,
  input  logic                step_pair,
  input  logic                step_down,
  output logic [2*PTR_W-1:0]  hl,
  output logic [2*PTR_W-1:0]  xy,
  output logic [DATA_W-1:0]   acc,
  output logic                zflag
);

  logic [PTR_W-1:0] hl_hi, hl_lo, xy_hi, xy_lo;
  logic [PTR_W-1:0] step_src, step_res;

  function automatic logic [PTR_W-1:0] step_nib(input logic [PTR_W-1:0] v,
                                                input logic down);
    return down ? (v - 1'b1) : (v + 1'b1);
  endfunction

  always_comb begin
    step_src = step_pair ? xy_lo : hl_lo;
    step_res = step_nib(step_src, step_down);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hl_hi <= '0;
      hl_lo <= '0;
      xy_hi <= '0;
      xy_lo <= '0;
      zflag <= 1'b0;
    end else if (imm_we) begin
      if (imm_pair) begin
        xy_hi <= imm_hi;
        xy_lo <= imm_lo;
      end else begin
        hl_hi <= imm_hi;
        hl_lo <= imm_lo;
      end
    end else if (step_fire) begin
      if (step_pair) xy_lo <= step_res;
      else           hl_lo <= step_res;
      zflag <= (step_res == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (ac_we) acc <= ac_d;
  end

  assign hl = {hl_hi, hl_lo};
  assign xy = {xy_hi, xy_lo};

endmodule

// File: rtl/nptr_ctrl.sv
module nptr_ctrl
  import nptr_pkg::*;
#(
  parameter int PTR_W  = 4,
  parameter int DATA_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instr_valid,
  input  logic [OP_W-1:0]     instr_op,
  input  logic [2*PTR_W-1:0]  instr_imm,
  input  dec_t                dec,
  input  logic                dec_mem,
  input  logic [2*PTR_W-1:0]  hl,
  input  logic [2*PTR_W-1:0]  xy,
  input  logic [DATA_W-1:0]   acc,
  input  logic [DATA_W-1:0]   ram_rdata,
  output logic                instr_ready,
  output logic                done,
  output logic [1:0]          done_cycles,
  output logic                ram_re,
  output logic                ram_we,
  output logic [2*PTR_W-1:0]  ram_addr,
  output logic [DATA_W-1:0]   ram_wdata,
  output logic                imm_we,
  output logic                imm_pair,
  output logic [PTR_W-1:0]    imm_hi,
  output logic [PTR_W-1:0]    imm_lo,
  output logic                ac_we,
  output logic [DATA_W-1:0]   ac_d,
  output logic                step_fire,
  output logic                step_pair,
  output logic                step_down,
  output logic                xch_hold_fire,
  output logic                none_fire,
  output logic                ldz_fire
);

  localparam int ADDR_W = 2 * PTR_W;

  typedef enum logic {S_IDLE, S_EXEC} st_e;

  st_e               st;
  dec_t              ex_dec;
  logic [ADDR_W-1:0] ex_addr;
  logic [ADDR_W-1:0] addr_now;
  logic              accept;
  logic              in_exec;

  assign instr_ready = (st == S_IDLE);
  assign accept      = instr_valid && instr_ready;
  assign in_exec     = (st == S_EXEC);

  always_comb begin
    if (dec.kind == K_XDIR) addr_now = instr_imm;
    else if (dec.pair)      addr_now = xy;
    else                    addr_now = hl;
  end

  // RAM port: read at acceptance, write-back in the execute cycle
  assign ram_re    = accept && dec_mem;
  assign ram_we    = in_exec && (ex_dec.kind != K_LOAD);
  assign ram_addr  = in_exec ? ex_addr : addr_now;
  assign ram_wdata = acc;

  // immediate pointer loads
  assign ldz_fire  = accept && (dec.kind == K_LDZ);
  assign imm_we    = accept && ((dec.kind == K_LDZ) || (dec.kind == K_LDPAIR));
  assign imm_pair  = (dec.kind == K_LDPAIR) ? dec.pair : 1'b0;
  assign imm_hi    = (dec.kind == K_LDZ) ? '0 : instr_imm[ADDR_W-1:PTR_W];
  assign imm_lo    = (dec.kind == K_LDZ) ? PTR_W'(instr_op[3:0])
                                         : instr_imm[PTR_W-1:0];
  assign none_fire = accept && (dec.kind == K_NONE);

  // execute cycle effects
  assign ac_we         = in_exec;
  assign ac_d          = ram_rdata;
  assign step_fire     = in_exec && ex_dec.step;
  assign step_pair     = ex_dec.pair;
  assign step_down     = ex_dec.down;
  assign xch_hold_fire = in_exec && !ex_dec.step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ex_dec      <= '0;
      ex_addr     <= '0;
      done        <= 1'b0;
      done_cycles <= 2'd0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (accept && dec_mem) begin
            st      <= S_EXEC;
            ex_dec  <= dec;
            ex_addr <= addr_now;
          end else if (imm_we) begin
            done        <= 1'b1;
            done_cycles <= dec.cyc;
          end
        end
        S_EXEC: begin
          st          <= S_IDLE;
          done        <= 1'b1;
          done_cycles <= ex_dec.cyc;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nptr_unit.sv
module nptr_unit
  import nptr_pkg::*;
#(
  parameter int PTR_W  = 4,
  parameter int DATA_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instr_valid,
  input  logic [7:0]          instr_op,
  input  logic [2*PTR_W-1:0]  instr_imm,
  output logic                instr_ready,
  output logic                done,
  output logic [1:0]          done_cycles,
  output logic                ram_re,
  output logic                ram_we,
  output logic [2*PTR_W-1:0]  ram_addr,
  output logic [DATA_W-1:0]   ram_wdata,
  input  logic [DATA_W-1:0]   ram_rdata,
  output logic [DATA_W-1:0]   acc,
  output logic                zflag,
  output logic [2*PTR_W-1:0]  hl_ptr,
  output logic [2*PTR_W-1:0]  xy_ptr
);

  dec_t             dec;
  logic             dec_mem;
  logic             imm_we, imm_pair;
  logic [PTR_W-1:0] imm_hi, imm_lo;
  logic             ac_we;
  logic [DATA_W-1:0] ac_d;
  // named events, observed by the checker
  logic             step_fire, step_pair, step_down;
  logic             xch_hold_fire, none_fire, ldz_fire;

  nptr_decode u_dec (
    .op     (instr_op),
    .dec    (dec),
    .is_mem (dec_mem)
  );

  nptr_ctrl #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .instr_op      (instr_op),
    .instr_imm     (instr_imm),
    .dec           (dec),
    .dec_mem       (dec_mem),
    .hl            (hl_ptr),
    .xy            (xy_ptr),
    .acc           (acc),
    .ram_rdata     (ram_rdata),
    .instr_ready   (instr_ready),
    .done          (done),
    .done_cycles   (done_cycles),
    .ram_re        (ram_re),
    .ram_we        (ram_we),
    .ram_addr      (ram_addr),
    .ram_wdata     (ram_wdata),
    .imm_we        (imm_we),
    .imm_pair      (imm_pair),
    .imm_hi        (imm_hi),
    .imm_lo        (imm_lo),
    .ac_we         (ac_we),
    .ac_d          (ac_d),
    .step_fire     (step_fire),
    .step_pair     (step_pair),
    .step_down     (step_down),
    .xch_hold_fire (xch_hold_fire),
    .none_fire     (none_fire),
    .ldz_fire      (ldz_fire)
  );

  nptr_ptrfile #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .imm_we    (imm_we),
    .imm_pair  (imm_pair),
    .imm_hi    (imm_hi),
    .imm_lo    (imm_lo),
    .ac_we     (ac_we),
    .ac_d      (ac_d),
    .step_fire (step_fire),
    .step_pair (step_pair),
    .step_down (step_down),
    .hl        (hl_ptr),
    .xy        (xy_ptr),
    .acc       (acc),
    .zflag     (zflag)
  );

endmodule

// File: rtl/nptr_unit_chk.sv
module nptr_unit_chk #(
  parameter int PTR_W  = 4,
  parameter int DATA_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               instr_ready,
  input logic               done,
  input logic               ram_re,
  input logic               ram_we,
  input logic [2*PTR_W-1:0] ram_addr,
  input logic [DATA_W-1:0]  acc,
  input logic               zflag,
  input logic [2*PTR_W-1:0] hl_ptr,
  input logic [2*PTR_W-1:0] xy_ptr,
  input logic               step_fire,
  input logic               step_pair,
  input logic               xch_hold_fire,
  input logic               none_fire,
  input logic               ldz_fire
);

  // R1
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ($past(ram_re) && ram_addr == $past(ram_addr)));

  // R2
  step_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> (hl_ptr[2*PTR_W-1:PTR_W] == $past(hl_ptr[2*PTR_W-1:PTR_W])
                && xy_ptr[2*PTR_W-1:PTR_W] == $past(xy_ptr[2*PTR_W-1:PTR_W])));

  // R6
  step_zf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> (zflag == (($past(step_pair) ? xy_ptr[PTR_W-1:0]
                                               : hl_ptr[PTR_W-1:0]) == '0)));

  // R4
  xch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xch_hold_fire |=> ($stable(zflag) && $stable(hl_ptr) && $stable(xy_ptr)));

  // R7
  ldz_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ldz_fire |=> (hl_ptr[2*PTR_W-1:PTR_W] == '0 && $stable(zflag)));

  // R10
  mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |=> (!instr_ready && !done));

  // R11
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    none_fire |=> ($stable(hl_ptr) && $stable(xy_ptr) && $stable(acc)
                   && $stable(zflag) && !done));

  // R1
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_re, ram_we}));

endmodule

bind nptr_unit nptr_unit_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_ready   (instr_ready),
  .done          (done),
  .ram_re        (ram_re),
  .ram_we        (ram_we),
  .ram_addr      (ram_addr),
  .acc           (acc),
  .zflag         (zflag),
  .hl_ptr        (hl_ptr),
  .xy_ptr        (xy_ptr),
  .step_fire     (step_fire),
  .step_pair     (step_pair),
  .xch_hold_fire (xch_hold_fire),
  .none_fire     (none_fire),
  .ldz_fire      (ldz_fire)
);

// File: tb/nptr_unit_bench.sv
module nptr_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  // {op, imm, exp_hl, exp_xy, exp_ac, exp_zf, exp_cyc, mem_en, mem_addr, mem_val}
  localparam logic [51:0] TBL [NVEC] = '{
    {8'hC4, 8'h3E, 8'h3E, 8'h00, 4'h0, 1'b0, 2'd2, 1'b0, 8'h00, 4'h0},
    {8'hC5, 8'h70, 8'h3E, 8'h70, 4'h0, 1'b0, 2'd2, 1'b0, 8'h00, 4'h0},
    {8'h49, 8'h00, 8'h3F, 8'h70, 4'hD, 1'b0, 2'd2, 1'b0, 8'h00, 4'h0},
    {8'h49, 8'h00, 8'h30, 8'h70, 4'hC, 1'b1, 2'd2, 1'b0, 8'h00, 4'h0},
    {8'h5B, 8'h00, 8'h30, 8'h7F, 4'h7, 1'b0, 2'd2, 1'b0, 8'h00, 4'h0},
    {8'h4C, 8'h00, 8'h30, 8'h7F, 4'h3, 1'b0, 2'd1, 1'b1, 8'h30, 4'h7},
    {8'h4F, 8'h00, 8'h30, 8'h70, 4'h8, 1'b1, 2'd2, 1'b1, 8'h7F, 4'h3},
    {8'h5F, 8'h00, 8'h30, 8'h7F, 4'h7, 1'b0, 2'd2, 1'b1, 8'h70, 4'h8},
    {8'h65, 8'h00, 8'h05, 8'h7F, 4'h7, 1'b0, 2'd1, 1'b0, 8'h00, 4'h0},
    {8'hC2, 8'hA2, 8'h05, 8'h7F, 4'h8, 1'b0, 2'd2, 1'b1, 8'hA2, 4'h7},
    {8'hFF, 8'h00, 8'h05, 8'h7F, 4'h8, 1'b0, 2'd0, 1'b0, 8'h00, 4'h0},
    {8'h59, 8'h00, 8'h04, 8'h7F, 4'h5, 1'b0, 2'd2, 1'b0, 8'h00, 4'h0},
    {8'h5D, 8'h00, 8'h03, 8'h7F, 4'h4, 1'b0, 2'd2, 1'b1, 8'h04, 4'h5},
    {8'h4B, 8'h00, 8'h03, 8'h70, 4'h3, 1'b1, 2'd2, 1'b0, 8'h00, 4'h0},
    {8'h60, 8'h00, 8'h00, 8'h70, 4'h3, 1'b1, 2'd1, 1'b0, 8'h00, 4'h0},
    {8'h5D, 8'h00, 8'h0F, 8'h70, 4'h0, 1'b0, 2'd2, 1'b1, 8'h00, 4'h3}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       instr_valid = 1'b0;
  logic [7:0] instr_op = 8'h00;
  logic [7:0] instr_imm = 8'h00;
  logic       instr_ready, done, ram_re, ram_we, zflag;
  logic [1:0] done_cycles;
  logic [7:0] ram_addr, hl_ptr, xy_ptr;
  logic [3:0] ram_wdata, ram_rdata, acc;
  logic [3:0] mem [256];

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] prev_hl = 8'h00;
  logic [7:0] prev_xy = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  nptr_unit u_nptr_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_op    (instr_op),
    .instr_imm   (instr_imm),
    .instr_ready (instr_ready),
    .done        (done),
    .done_cycles (done_cycles),
    .ram_re      (ram_re),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .ram_wdata   (ram_wdata),
    .ram_rdata   (ram_rdata),
    .acc         (acc),
    .zflag       (zflag),
    .hl_ptr      (hl_ptr),
    .xy_ptr      (xy_ptr)
  );

  // synchronous RAM model
  always @(posedge clk) begin
    if (ram_re) ram_rdata <= mem[ram_addr];
    if (ram_we) mem[ram_addr] <= ram_wdata;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [7:0] op);
    if (op[7:4] == 4'h6)             return "R7";
    if (op == 8'hC4 || op == 8'hC5)  return "R8";
    if (op == 8'hC2)                 return "R9";
    if (op[7:5] == 3'b010 && op[3]) begin
      if (!op[2] && op[0])           return op[4] ? "R3" : "R2";
      if (op[2] && op[0])            return "R5";
      if (op[2] && !op[4])           return "R4";
    end
    return "R11";
  endfunction

  task automatic run_vec(input logic [51:0] v, input string tag);
    logic [7:0] op, imm, e_hl, e_xy, m_addr, e_addr;
    logic [3:0] e_ac, m_val;
    logic       e_zf, m_en, is_mem, seen_busy;
    logic [1:0] e_cyc;
    int         lat;
    {op, imm, e_hl, e_xy, e_ac, e_zf, e_cyc, m_en, m_addr, m_val} = v;
    is_mem = ((op[7:5] == 3'b010) && op[3] && (e_cyc != 2'd0)) || (op == 8'hC2);
    e_addr = (op == 8'hC2) ? imm : (op[1] ? prev_xy : prev_hl);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_op    = op;
    instr_imm   = imm;
    #1;
    if (is_mem) begin
      chk(ram_re && ram_addr == e_addr, "R1", "read address", ram_addr, e_addr);
    end else begin
      chk(!ram_re, "R11", "no read for non-memory op", ram_re, 0);
    end
    @(negedge clk);
    instr_valid = 1'b0;
    lat = 1;
    seen_busy = !instr_ready;
    while (!done && lat < 4) begin
      @(negedge clk);
      lat++;
    end
    if (e_cyc == 2'd0) begin
      chk(!done, "R11", "done for ignored op", done, 0);
    end else begin
      chk(lat == (is_mem ? 2 : 1), "R10", "done latency", lat, is_mem ? 2 : 1);
      chk(done_cycles == e_cyc, "R10", "done_cycles", done_cycles, e_cyc);
      if (is_mem) chk(seen_busy, "R10", "busy during exec", !seen_busy, 0);
    end
    chk(hl_ptr == e_hl, tag, "hl pointer", hl_ptr, e_hl);
    chk(xy_ptr == e_xy, tag, "xy pointer", xy_ptr, e_xy);
    chk(acc == e_ac, tag, "accumulator", acc, e_ac);
    chk(zflag == e_zf, tag, "zero flag", zflag, e_zf);
    if (m_en) chk(mem[m_addr] == m_val, tag, "ram contents", mem[m_addr], m_val);
    prev_hl = e_hl;
    prev_xy = e_xy;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 4'(i[3:0] ^ i[7:4]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    chk(hl_ptr == 8'h00 && xy_ptr == 8'h00, "R12", "pointers after reset",
        {hl_ptr, xy_ptr}, 0);
    chk(acc == 4'h0 && !zflag, "R12", "acc/zf after reset", {acc, zflag}, 0);
    chk(instr_ready && !done, "R12", "ready/done after reset",
        {instr_ready, done}, 2);

    for (int k = 0; k < NVEC; k++) run_vec(TBL[k], req_of(TBL[k][51:44]));

    // R6 wrap: HL=0F, load-increment gives 00 with flag set
    run_vec({8'h49, 8'h00, 8'h00, 8'h70, 4'hF, 1'b1, 2'd2, 1'b0, 8'h00, 4'h0}, "R6");
    // R6 wrap: HL=00, load-decrement gives 0F with flag clear
    run_vec({8'h59, 8'h00, 8'h0F, 8'h70, 4'h3, 1'b0, 2'd2, 1'b0, 8'h00, 4'h0}, "R6");

    // R12 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(hl_ptr == 8'h00 && xy_ptr == 8'h00 && acc == 4'h0 && !zflag,
        "R12", "state after second reset", {hl_ptr, xy_ptr, acc}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    summary();
    $finish;
  end

endmodule